// File: doc/BRIEF.md
# Split-Band Hysteresis Gate Controller

This block turns sampled current references and measured inverter output currents into gate commands for a three-phase, two-level inverter. Every phase owns two hysteresis decisions, one for the high-side switch and one for the low-side switch. A mode input picks one of two schemes. In the complementary scheme a single latched decision drives the high side and, inverted, the low side. In the split-band scheme each switch has its own pair of thresholds. Near the current zero crossing both switches of a leg can then stay off, so the leg does not switch there.

Decisions are taken only on a sample strobe, which the surrounding system pulses at its sampling rate. Between strobes every decision keeps its value. The decisions then pass through a per-leg dead-time stage. The two gates of a leg are never on together, and a switch that follows its opposite partner waits a programmable number of clock cycles with the whole leg off. Currents and band are signed 16-bit two's-complement values. The threshold arithmetic saturates.

Top module: `split_band_gate_ctrl`

## Requirements
- R1: Split-band mode (`mode_split`=1), high side: on a strobe the high-side decision is cleared when meas >= ref. Otherwise it is set when meas <= sat(ref - band). Otherwise it holds.
- R2: Split-band mode, low side: on a strobe the low-side decision is cleared when meas <= ref. Otherwise it is set when meas >= sat(ref + band). Otherwise it holds. With meas strictly between ref and ref+band, and the high side already off, both gates stay off.
- R3: Complementary mode (`mode_split`=0): on a strobe, meas <= sat(ref - band) selects high side on and low side off. Otherwise meas >= sat(ref + band) selects low side on and high side off. Otherwise the decision holds. When both conditions hold (band 0, meas equal to ref), the high side wins.
- R4: The high and low gates of one leg are never both 1.
- R5: Without a strobe no decision changes, whatever the current inputs do.
- R6: sat() clamps ref ± band to the range -32768..32767 instead of wrapping.
- R7: A gate turns off on the clock edge after its decision drops. A gate that turns on after the opposite gate of its leg was the last one on is delayed so that both gates are off for exactly DEAD_CYC clock cycles. A gate that was itself the last one on turns on again one edge after its decision.
- R8: If on a strobe the band is negative and both on-conditions hold (meas <= sat(ref-band) and meas >= sat(ref+band)), both decisions are cleared and that phase's fault output goes to 1. The next strobe without this condition returns it to 0.
- R9: Reset drives all six gates and all fault outputs to 0, and after reset the first turn-on needs no dead-time wait.
- R10: The three phases are independent: inputs of one phase never change another phase's outputs.
- R11: A decision updates on the edge that samples the strobe, and the gates follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe that triggers the comparisons |
| mode_split | input | 1 | 1 = split-band scheme, 0 = complementary scheme |
| band_i | input | 16 | Signed hysteresis band width |
| ref_i | input | 3x16 | Signed current reference per phase |
| meas_i | input | 3x16 | Signed measured current per phase |
| gate_hi_o | output | 3 | High-side gate per leg |
| gate_lo_o | output | 3 | Low-side gate per leg |
| fault_o | output | 3 | Conflicting on-conditions seen at the last strobe, per phase |

## Verification
The collision that matters here is a new strobe that reverses a leg's decision while that leg's dead-time count from the previous reversal is still running. A fault strobe can also clear a decision that the dead-time stage is just about to grant. Random strobes arrive every few cycles, with the dead time set to six cycles and measured currents scattered across both bands, so both collisions occur. A cycle-level model of the requirements judges every gate and fault output on every cycle. Directed cases count the exact off window, saturate the thresholds at both rails, and force a negative band.

// File: rtl/hyst_pkg.sv
`timescale 1ns/1ps
package hyst_pkg;

    typedef enum logic {
        MODE_CLASSIC = 1'b0,
        MODE_SPLIT   = 1'b1
    } hyst_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_cmd_t;

endpackage

// File: rtl/hyst_phase_decide.sv
`timescale 1ns/1ps
module hyst_phase_decide
    import hyst_pkg::*;
#(
    parameter int CUR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_stb,
    input  hyst_mode_e              mode,
    input  logic signed [CUR_W-1:0] ref_i,
    input  logic signed [CUR_W-1:0] meas_i,
    input  logic signed [CUR_W-1:0] band_i,
    output leg_cmd_t                cmd_o,
    output logic                    fault_o
);

    localparam int EXT_W = CUR_W + 1;
    localparam logic signed [CUR_W-1:0] VMAX = {1'b0, {(CUR_W-1){1'b1}}};
    localparam logic signed [CUR_W-1:0] VMIN = {1'b1, {(CUR_W-1){1'b0}}};

    typedef struct packed {
        logic up;
        logic dn;
        logic fault;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic signed [EXT_W-1:0] sum_lo, sum_hi;
    logic signed [CUR_W-1:0] thr_lo, thr_hi;
    logic up_on, up_off, dn_on, dn_off, band_neg;

    function automatic logic signed [CUR_W-1:0] clamp_ext(input logic signed [EXT_W-1:0] v);
        if (v > $signed({1'b0, VMAX}))
            return VMAX;
        else if (v < $signed({1'b1, VMIN}))
            return VMIN;
        else
            return v[CUR_W-1:0];
    endfunction

    always_comb begin
        sum_lo   = {ref_i[CUR_W-1], ref_i} - {band_i[CUR_W-1], band_i};
        sum_hi   = {ref_i[CUR_W-1], ref_i} + {band_i[CUR_W-1], band_i};
        thr_lo   = clamp_ext(sum_lo);
        thr_hi   = clamp_ext(sum_hi);
        up_on    = (meas_i <= thr_lo);
        up_off   = (meas_i >= ref_i);
        dn_on    = (meas_i >= thr_hi);
        dn_off   = (meas_i <= ref_i);
        band_neg = band_i[CUR_W-1];

        st_d = st_q;
        if (sample_stb) begin
            if (band_neg && up_on && dn_on) begin
                st_d.up    = 1'b0;
                st_d.dn    = 1'b0;
                st_d.fault = 1'b1;
            end else begin
                st_d.fault = 1'b0;
                if (mode == MODE_SPLIT) begin
                    if (up_off)
                        st_d.up = 1'b0;
                    else if (up_on)
                        st_d.up = 1'b1;
                    if (dn_off)
                        st_d.dn = 1'b0;
                    else if (dn_on)
                        st_d.dn = 1'b1;
                end else begin
                    if (up_on) begin
                        st_d.up = 1'b1;
                        st_d.dn = 1'b0;
                    end else if (dn_on) begin
                        st_d.up = 1'b0;
                        st_d.dn = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{default: 1'b0};
        else
            st_q <= st_d;
    end

    assign cmd_o.hi = st_q.up;
    assign cmd_o.lo = st_q.dn;
    assign fault_o  = st_q.fault;

    // R1: a strobe with measured current at or above the reference always leaves the high side off
    assert_upper_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && mode == MODE_SPLIT && meas_i >= ref_i) |=> !st_q.up);

    // R2: a strobe with measured current at or below the reference always leaves the low side off
    assert_lower_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && mode == MODE_SPLIT && meas_i <= ref_i) |=> !st_q.dn);

    // R5: decisions only move on a strobe
    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(st_q));

    // R8: a flagged fault comes with both decisions off
    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |-> (!st_q.up && !st_q.dn));

    // R4: the decisions of one leg are exclusive
    assert_cmd_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.up && st_q.dn));

endmodule

// File: rtl/leg_deadtime.sv
`timescale 1ns/1ps
module leg_deadtime
    import hyst_pkg::*;
#(
    parameter int DEAD_CYC = 165
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_t cmd_i,
    output logic     gate_hi_o,
    output logic     gate_lo_o
);

    localparam int CNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(DEAD_CYC);
    localparam logic [CNT_W-1:0] GRANT_AT = CNT_W'(DEAD_CYC - 1);

    typedef struct packed {
        logic             hi;
        logic             lo;
        logic             last_lo;
        logic [CNT_W-1:0] cnt;
    } dt_state_t;

    dt_state_t dt_d, dt_q;
    logic wait_done;

    always_comb begin
        wait_done = (dt_q.cnt >= GRANT_AT);
        dt_d.hi = cmd_i.hi && !cmd_i.lo && !dt_q.lo &&
                  (dt_q.hi || !dt_q.last_lo || wait_done);
        dt_d.lo = cmd_i.lo && !cmd_i.hi && !dt_q.hi &&
                  (dt_q.lo || dt_q.last_lo || wait_done);
        if (dt_q.lo)
            dt_d.last_lo = 1'b1;
        else if (dt_q.hi)
            dt_d.last_lo = 1'b0;
        else
            dt_d.last_lo = dt_q.last_lo;
        if (dt_q.hi || dt_q.lo)
            dt_d.cnt = '0;
        else if (dt_q.cnt == CNT_SAT)
            dt_d.cnt = dt_q.cnt;
        else
            dt_d.cnt = dt_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_q.hi      <= 1'b0;
            dt_q.lo      <= 1'b0;
            dt_q.last_lo <= 1'b0;
            dt_q.cnt     <= CNT_SAT;
        end else begin
            dt_q <= dt_d;
        end
    end

    assign gate_hi_o = dt_q.hi;
    assign gate_lo_o = dt_q.lo;

    // R4: shoot-through never occurs on a leg
    assert_no_shoot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_o && gate_lo_o));

    // R7: a high-side turn-on is never adjacent to a low-side on cycle
    assert_gap_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi_o) |-> !$past(gate_lo_o));

    // R7: a low-side turn-on is never adjacent to a high-side on cycle
    assert_gap_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo_o) |-> !$past(gate_hi_o));

    // R7: a dropped decision turns the gate off on the next edge
    assert_prompt_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_i.hi && !cmd_i.lo) |=> (!gate_hi_o && !gate_lo_o));

endmodule

// File: rtl/split_band_gate_ctrl.sv
`timescale 1ns/1ps
module split_band_gate_ctrl
    import hyst_pkg::*;
#(
    parameter int N_PH     = 3,
    parameter int CUR_W    = 16,
    parameter int DEAD_CYC = 165
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_stb,
    input  logic                        mode_split,
    input  logic signed [CUR_W-1:0]     band_i,
    input  logic [N_PH-1:0][CUR_W-1:0]  ref_i,
    input  logic [N_PH-1:0][CUR_W-1:0]  meas_i,
    output logic [N_PH-1:0]             gate_hi_o,
    output logic [N_PH-1:0]             gate_lo_o,
    output logic [N_PH-1:0]             fault_o
);

    hyst_mode_e mode_sel;
    assign mode_sel = hyst_mode_e'(mode_split);

    for (genvar ph = 0; ph < N_PH; ph++) begin : g_phase
        leg_cmd_t cmd;

        hyst_phase_decide #(
            .CUR_W (CUR_W)
        ) decide_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_stb (sample_stb),
            .mode       (mode_sel),
            .ref_i      ($signed(ref_i[ph])),
            .meas_i     ($signed(meas_i[ph])),
            .band_i     (band_i),
            .cmd_o      (cmd),
            .fault_o    (fault_o[ph])
        );

        leg_deadtime #(
            .DEAD_CYC (DEAD_CYC)
        ) dead_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_i     (cmd),
            .gate_hi_o (gate_hi_o[ph]),
            .gate_lo_o (gate_lo_o[ph])
        );
    end

    // R9: outputs are quiet in the cycle after reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (gate_hi_o == '0 && gate_lo_o == '0 && fault_o == '0));

endmodule

// File: tb/split_band_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module split_band_gate_ctrl_tb_top;

    localparam int NP   = 3;
    localparam int DEAD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic mode_split = 1'b0;
    logic signed [15:0] band_v = '0;
    logic [NP-1:0][15:0] ref_v = '0;
    logic [NP-1:0][15:0] meas_v = '0;
    logic [NP-1:0] g_hi_o, g_lo_o, flt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    bit m_up[NP], m_dn[NP], m_flt[NP];
    bit g_hi[NP], g_lo[NP], last_lo[NP];
    int cnt[NP];

    always #10 clk = ~clk;

    split_band_gate_ctrl #(.N_PH(NP), .CUR_W(16), .DEAD_CYC(DEAD)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(stb), .mode_split(mode_split),
        .band_i(band_v), .ref_i(ref_v), .meas_i(meas_v),
        .gate_hi_o(g_hi_o), .gate_lo_o(g_lo_o), .fault_o(flt_o)
    );

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_up[p] = 0; m_dn[p] = 0; m_flt[p] = 0;
            g_hi[p] = 0; g_lo[p] = 0; last_lo[p] = 0; cnt[p] = DEAD;
        end
    endtask

    // one clock edge of the requirements model, using the inputs now applied
    task automatic model_edge();
        for (int p = 0; p < NP; p++) begin
            bit nh, nl, nll;
            int nc, r, m, b, tl, th;
            bit uon, uoff, don, doff;
            nh = m_up[p] && !m_dn[p] && !g_lo[p] && (g_hi[p] || !last_lo[p] || cnt[p] >= DEAD - 1);
            nl = m_dn[p] && !m_up[p] && !g_hi[p] && (g_lo[p] || last_lo[p] || cnt[p] >= DEAD - 1);
            nll = g_lo[p] ? 1'b1 : (g_hi[p] ? 1'b0 : last_lo[p]);
            nc = (g_hi[p] || g_lo[p]) ? 0 : ((cnt[p] >= DEAD) ? DEAD : cnt[p] + 1);
            g_hi[p] = nh; g_lo[p] = nl; last_lo[p] = nll; cnt[p] = nc;
            if (stb) begin
                r = int'($signed(ref_v[p]));
                m = int'($signed(meas_v[p]));
                b = int'(band_v);
                tl = sat16(r - b);
                th = sat16(r + b);
                uon = (m <= tl); uoff = (m >= r);
                don = (m >= th); doff = (m <= r);
                if (b < 0 && uon && don) begin
                    m_up[p] = 0; m_dn[p] = 0; m_flt[p] = 1;
                end else begin
                    m_flt[p] = 0;
                    if (mode_split) begin
                        if (uoff) m_up[p] = 0; else if (uon) m_up[p] = 1;
                        if (doff) m_dn[p] = 0; else if (don) m_dn[p] = 1;
                    end else begin
                        if (uon) begin m_up[p] = 1; m_dn[p] = 0; end
                        else if (don) begin m_up[p] = 0; m_dn[p] = 1; end
                    end
                end
            end
        end
    endtask

    // apply current inputs for one cycle, then compare every output with the model
    task automatic step(input bit s);
        stb = s;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        stb = 1'b0;
        for (int p = 0; p < NP; p++) begin
            chk(g_hi_o[p] == g_hi[p] && g_lo_o[p] == g_lo[p] && flt_o[p] == m_flt[p],
                $sformatf("R1 R2 R3 R7 R8 model ph%0d hi=%b lo=%b flt=%b exp hi=%b lo=%b flt=%b",
                          p, g_hi_o[p], g_lo_o[p], flt_o[p], g_hi[p], g_lo[p], m_flt[p]));
            chk(!(g_hi_o[p] && g_lo_o[p]), $sformatf("R4 ph%0d both gates on", p));
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic put(input int p, input int r, input int m);
        ref_v[p]  = 16'(r);
        meas_v[p] = 16'(m);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int offc;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(g_hi_o == '0 && g_lo_o == '0 && flt_o == '0,
            $sformatf("R9 reset hi=%b lo=%b flt=%b exp 000", g_hi_o, g_lo_o, flt_o));
        rst_n = 1'b1;
        settle(2);

        // R1 split high side sets below ref-band, first turn-on immediate (R9, R11)
        mode_split = 1'b1; band_v = 16'sd100;
        put(0, 1000, 850); put(1, 0, 0); put(2, 0, 0);
        step(1'b1);
        chk(g_hi_o[0] == 1'b0, $sformatf("R11 gate before latency hi=%b exp 0", g_hi_o[0]));
        step(1'b0);
        chk(g_hi_o[0] == 1'b1, $sformatf("R1 R9 upper on hi=%b exp 1", g_hi_o[0]));
        // R10 other legs untouched
        chk(g_hi_o[2:1] == 2'b00 && g_lo_o[2:1] == 2'b00,
            $sformatf("R10 others hi=%b lo=%b exp 00", g_hi_o[2:1], g_lo_o[2:1]));
        // R5 crossing without strobe is ignored
        put(0, 1000, 1200);
        settle(4);
        chk(g_hi_o[0] == 1'b1 && g_lo_o[0] == 1'b0,
            $sformatf("R5 no strobe hi=%b lo=%b exp 1 0", g_hi_o[0], g_lo_o[0]));
        // R1 release at reference, R2 zero-crossing window: both off
        put(0, 1000, 1050);
        step(1'b1); settle(10);
        chk(g_hi_o[0] == 1'b0 && g_lo_o[0] == 1'b0,
            $sformatf("R2 window hi=%b lo=%b exp 0 0", g_hi_o[0], g_lo_o[0]));
        // R2 low side sets at ref+band
        put(0, 1000, 1100);
        step(1'b1); settle(10);
        chk(g_lo_o[0] == 1'b1, $sformatf("R2 lower on lo=%b exp 1", g_lo_o[0]));
        put(0, 1000, 1000);
        step(1'b1); settle(2);
        chk(g_lo_o[0] == 1'b0, $sformatf("R2 lower release lo=%b exp 0", g_lo_o[0]));

        // R6 saturation at both rails
        band_v = 16'sd2000;
        put(0, 32000, 32500);
        step(1'b1); settle(10);
        chk(g_lo_o[0] == 1'b0, $sformatf("R6 top rail lo=%b exp 0", g_lo_o[0]));
        put(1, -32000, -32500);
        step(1'b1); settle(10);
        chk(g_hi_o[1] == 1'b0, $sformatf("R6 bottom rail hi=%b exp 0", g_hi_o[1]));

        // R3 complementary mode, tie at band 0 picks high side
        mode_split = 1'b0; band_v = 16'sd0;
        put(0, 0, 0); put(1, 0, 0);
        step(1'b1); settle(10);
        chk(g_hi_o[0] == 1'b1 && g_lo_o[0] == 1'b0,
            $sformatf("R3 tie hi=%b lo=%b exp 1 0", g_hi_o[0], g_lo_o[0]));
        // R7 exact off window when reversing
        band_v = 16'sd100;
        put(0, 0, -200); put(1, 0, 0); put(2, 0, 0);
        step(1'b1); settle(10);
        put(0, 0, 200);
        step(1'b1);
        offc = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b0);
            if (!g_hi_o[0] && !g_lo_o[0]) offc++;
            if (g_lo_o[0]) break;
        end
        chk(offc == DEAD && g_lo_o[0] == 1'b1,
            $sformatf("R7 off window %0d lo=%b exp %0d 1", offc, g_lo_o[0], DEAD));
        // R3 in-band holds
        put(0, 0, 50);
        step(1'b1); settle(3);
        chk(g_lo_o[0] == 1'b1, $sformatf("R3 hold lo=%b exp 1", g_lo_o[0]));

        // R8 negative band fault and recovery
        band_v = -16'sd100;
        put(0, 0, 20);
        step(1'b1);
        chk(flt_o[0] == 1'b1, $sformatf("R8 fault flt=%b exp 1", flt_o[0]));
        settle(2);
        chk(g_hi_o[0] == 1'b0 && g_lo_o[0] == 1'b0,
            $sformatf("R8 gates hi=%b lo=%b exp 0 0", g_hi_o[0], g_lo_o[0]));
        band_v = 16'sd100; put(0, 0, 0);
        step(1'b1);
        chk(flt_o[0] == 1'b0, $sformatf("R8 clear flt=%b exp 0", flt_o[0]));

        // random phase
        for (int it = 0; it < 4000; it++) begin
            if (it % 250 == 0) mode_split = $urandom % 2;
            if ($urandom % 64 == 0) band_v = -16'($urandom % 60) - 16'sd1;
            else if ($urandom % 16 == 0) band_v = 16'($urandom % 300);
            for (int p = 0; p < NP; p++) begin
                int r;
                if ($urandom % 8 == 0) begin
                    r = int'($urandom % 40001) - 20000;
                    ref_v[p] = 16'(r);
                end
                meas_v[p] = 16'(int'($signed(ref_v[p])) + int'($urandom % 801) - 400);
            end
            step(($urandom % 4) == 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule